// File: doc/BRIEF.md
# Flash In-System Programming Command Controller

This block is the register-side command engine that lets running software read, program and erase an embedded flash array. Software chooses an operation in a command register, names a word in an address register, and places program data in a data register. It then writes a start bit. The controller checks the request first. A legal request runs for a fixed number of busy cycles against a word-addressed memory model. When the operation completes, the start bit clears itself and, for a read, the fetched word appears in the data register.

A request that breaks a rule never starts. Instead it sets a sticky failure flag, which only software can clear and which does not block later requests. The enable bit and the three per-region update permissions can be changed only while the external unlock qualifier is high. While an operation is in flight, a stall line holds the processor. The flash is modelled as three consecutive regions: a main area, a boot area and a configuration area. The array is split into aligned pages of `PAGE_WORDS` words.

Top module: `flash_isp_ctrl`

## Requirements
- R1: After reset, every register reads zero, `cpu_stall` is low, and every flash word holds all ones.
- R2: Register offsets are 0 control, 1 command, 2 address, 3 data and 4 start. In the control register, bit 0 is enable, bit 1 allows updates to the main area, bit 2 to the boot area and bit 3 to the configuration area. These four bits change only on a write made while `prot_open` is 1.
- R3: A read (command code 0) loads the addressed word into the data register when the operation completes.
- R4: A program (command code 1) stores the bitwise AND of the old word and the data register, so it can only turn bits from 1 to 0.
- R5: An erase (command code 2) sets every word of the aligned `PAGE_WORDS` page that contains the address to all ones. Other pages are left unchanged.
- R6: Writing 1 to bit 0 of the start register launches an operation. The bit reads 1 while the operation is busy and `cpu_stall` equals it. The bit clears itself after `SHORT_CYC` cycles for a read or program and after `LONG_CYC` cycles for an erase.
- R7: A request is rejected if any of these holds: enable is clear, the address is at or beyond `MAIN_WORDS+BOOT_WORDS+CFG_WORDS`, the command code is 3, or a program or erase targets an area whose update bit is clear. A rejected request never raises the stall, leaves the flash unchanged and sets the failure flag (control bit 6).
- R8: The failure flag is cleared only by writing 1 to control bit 6, regardless of `prot_open`. Writing 0 there leaves it unchanged. A later successful operation runs normally and does not clear it.
- R9: Register writes made while an operation is busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prot_open | input | 1 | Unlock qualifier for the protected control bits |
| reg_wr | input | 1 | Register write strobe |
| reg_off | input | 3 | Register offset for both read and write |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data of the register at `reg_off` (combinational) |
| cpu_stall | output | 1 | Holds the processor while an operation is in flight |

## Verification
A vector table runs reads, programs and erases across all three areas and varies the permission mask on every entry. This separates a correct AND-merge from a plain overwrite, a page-wide erase from a single-word erase, and a permission check that follows the target area from one that ignores it. The rejection entries each break exactly one rule: disabled controller, out-of-range address, illegal command code, or missing permission. This shows that each rule alone suppresses the stall and raises the flag. Directed cases measure the busy length, attempt writes during the busy window and with the lock closed, and confirm that the failure flag survives both a successful operation and a write of 0.

// File: rtl/flash_isp_pkg.sv
package flash_isp_pkg;

    typedef enum logic [1:0] {
        CMD_READ  = 2'd0,
        CMD_PROG  = 2'd1,
        CMD_ERASE = 2'd2,
        CMD_BAD   = 2'd3
    } isp_cmd_e;

    typedef enum logic [2:0] {
        OFF_CTRL = 3'd0,
        OFF_CMD  = 3'd1,
        OFF_ADDR = 3'd2,
        OFF_DATA = 3'd3,
        OFF_GO   = 3'd4
    } isp_off_e;

    typedef struct packed {
        logic upd_cfg;
        logic upd_boot;
        logic upd_main;
        logic en;
    } isp_ctrl_t;

    localparam int FAIL_BIT = 6;

    // Decide whether a request must be refused before it starts.
    function automatic logic isp_reject(
        input isp_ctrl_t   c,
        input isp_cmd_e    k,
        input int unsigned a,
        input int unsigned n_main,
        input int unsigned n_boot,
        input int unsigned n_cfg
    );
        if (!c.en)                          return 1'b1;
        if (k == CMD_BAD)                   return 1'b1;
        if (a >= n_main + n_boot + n_cfg)   return 1'b1;
        if (k == CMD_READ)                  return 1'b0;
        if (a < n_main)                     return !c.upd_main;
        if (a < n_main + n_boot)            return !c.upd_boot;
        return !c.upd_cfg;
    endfunction

endpackage

// File: rtl/isp_mem_model.sv
module isp_mem_model
    import flash_isp_pkg::*;
#(
    parameter int DW         = 32,
    parameter int AW         = 8,
    parameter int WORDS      = 52,
    parameter int PAGE_WORDS = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic          prog_en,
    input  logic [DW-1:0] prog_data,
    input  logic          erase_en,
    output logic [DW-1:0] rdata
);
    localparam int IW = $clog2(WORDS);
    localparam int PB = $clog2(PAGE_WORDS);

    logic [DW-1:0] mem [WORDS];
    logic          in_range;

    assign in_range = (32'(addr) < WORDS);
    assign rdata    = in_range ? mem[addr[IW-1:0]] : '1;

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        localparam logic [AW-1:0] WADDR = AW'(w);
        logic hit_word;
        logic hit_page;
        assign hit_word = (addr == WADDR);
        assign hit_page = (addr[AW-1:PB] == WADDR[AW-1:PB]);

        always_ff @(posedge clk) begin
            if (rst) begin
                mem[w] <= '1;
            end else if (erase_en && hit_page) begin
                mem[w] <= '1;
            end else if (prog_en && hit_word) begin
                mem[w] <= mem[w] & prog_data;
            end
        end
    end

    // R4: programming never turns a 0 bit into 1
    a_r4_only_clears: assert property (@(posedge clk) disable iff (rst)
        (prog_en && !erase_en) |=> ((rdata & ~$past(rdata)) == '0));

endmodule

// File: rtl/isp_seq.sv
module isp_seq
    import flash_isp_pkg::*;
#(
    parameter int AW         = 8,
    parameter int MAIN_WORDS = 32,
    parameter int BOOT_WORDS = 16,
    parameter int CFG_WORDS  = 4,
    parameter int SHORT_CYC  = 2,
    parameter int LONG_CYC   = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_req,
    input  isp_ctrl_t     ctrl,
    input  isp_cmd_e      cmd,
    input  logic [AW-1:0] addr,
    output logic          go,
    output logic          done,
    output logic          fail_set,
    output isp_cmd_e      op
);
    localparam int CW = $clog2(LONG_CYC + 1);

    logic [CW-1:0] cnt;
    logic          reject;

    assign reject   = isp_reject(ctrl, cmd, 32'(addr),
                                 MAIN_WORDS, BOOT_WORDS, CFG_WORDS);
    assign done     = go && (cnt == '0);
    assign fail_set = start_req && !go && reject;

    always_ff @(posedge clk) begin
        if (rst) begin
            go  <= 1'b0;
            cnt <= '0;
            op  <= CMD_READ;
        end else if (!go) begin
            if (start_req && !reject) begin
                go  <= 1'b1;
                op  <= cmd;
                cnt <= (cmd == CMD_ERASE) ? CW'(LONG_CYC - 1) : CW'(SHORT_CYC - 1);
            end
        end else if (cnt == '0) begin
            go <= 1'b0;
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

    // R6: the start bit drops right after the final busy cycle
    a_r6_go_selfclear: assert property (@(posedge clk) disable iff (rst)
        (go && cnt == '0) |=> !go);

    // R7: a refused request never begins
    a_r7_reject_no_start: assert property (@(posedge clk) disable iff (rst)
        (!go && start_req && reject) |=> !go);

endmodule

// File: rtl/isp_regs.sv
module isp_regs
    import flash_isp_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          prot_open,
    input  logic          wr,
    input  logic [2:0]    off,
    input  logic [DW-1:0] wdata,
    input  logic          busy,
    input  logic          done,
    input  isp_cmd_e      op,
    input  logic          fail_set,
    input  logic [DW-1:0] mem_rdata,
    output isp_ctrl_t     ctrl,
    output isp_cmd_e      cmd,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] data,
    output logic          fail,
    output logic          start_req,
    output logic [DW-1:0] rdata
);
    logic wr_ok;
    logic fail_clr;

    assign wr_ok     = wr && !busy;
    assign start_req = wr_ok && (off == OFF_GO) && wdata[0];
    assign fail_clr  = wr_ok && (off == OFF_CTRL) && wdata[FAIL_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            cmd  <= CMD_READ;
            addr <= '0;
            data <= '0;
            fail <= 1'b0;
        end else begin
            if (wr_ok && off == OFF_CTRL && prot_open)
                ctrl <= isp_ctrl_t'(wdata[3:0]);
            if (wr_ok && off == OFF_CMD)
                cmd <= isp_cmd_e'(wdata[1:0]);
            if (wr_ok && off == OFF_ADDR)
                addr <= wdata[AW-1:0];
            if (done && op == CMD_READ)
                data <= mem_rdata;
            else if (wr_ok && off == OFF_DATA)
                data <= wdata;
            if (fail_set)
                fail <= 1'b1;
            else if (fail_clr)
                fail <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        case (off)
            OFF_CTRL: begin
                rdata[3:0]      = ctrl;
                rdata[FAIL_BIT] = fail;
            end
            OFF_CMD:  rdata[1:0]    = cmd;
            OFF_ADDR: rdata[AW-1:0] = addr;
            OFF_DATA: rdata         = data;
            OFF_GO:   rdata[0]      = busy;
            default:  rdata         = '0;
        endcase
    end

    // R2: protected bits hold unless a write arrives with the lock open
    a_r2_ctrl_locked: assert property (@(posedge clk) disable iff (rst)
        !(wr && prot_open) |=> $stable(ctrl));

    // R7: a refused request raises the flag
    a_r7_fail_on_reject: assert property (@(posedge clk) disable iff (rst)
        fail_set |=> fail);

    // R8: the flag falls only through the clear write
    a_r8_fail_sticky: assert property (@(posedge clk) disable iff (rst)
        (fail && !(wr && off == OFF_CTRL && wdata[FAIL_BIT])) |=> fail);

    // R9: the address cannot move while busy
    a_r9_addr_frozen: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(addr));

endmodule

// File: rtl/flash_isp_ctrl.sv
module flash_isp_ctrl
    import flash_isp_pkg::*;
#(
    parameter int DW         = 32,
    parameter int AW         = 8,
    parameter int MAIN_WORDS = 32,
    parameter int BOOT_WORDS = 16,
    parameter int CFG_WORDS  = 4,
    parameter int PAGE_WORDS = 4,
    parameter int SHORT_CYC  = 2,
    parameter int LONG_CYC   = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          prot_open,
    input  logic          reg_wr,
    input  logic [2:0]    reg_off,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          cpu_stall
);
    localparam int WORDS = MAIN_WORDS + BOOT_WORDS + CFG_WORDS;

    isp_ctrl_t     ctrl;
    isp_cmd_e      cmd;
    isp_cmd_e      op;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    logic [DW-1:0] mem_rdata;
    logic          fail;
    logic          start_req;
    logic          go;
    logic          done;
    logic          fail_set;

    assign cpu_stall = go;

    isp_regs #(.DW(DW), .AW(AW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .prot_open (prot_open),
        .wr        (reg_wr),
        .off       (reg_off),
        .wdata     (reg_wdata),
        .busy      (go),
        .done      (done),
        .op        (op),
        .fail_set  (fail_set),
        .mem_rdata (mem_rdata),
        .ctrl      (ctrl),
        .cmd       (cmd),
        .addr      (addr),
        .data      (data),
        .fail      (fail),
        .start_req (start_req),
        .rdata     (reg_rdata)
    );

    isp_seq #(
        .AW(AW), .MAIN_WORDS(MAIN_WORDS), .BOOT_WORDS(BOOT_WORDS),
        .CFG_WORDS(CFG_WORDS), .SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start_req (start_req),
        .ctrl      (ctrl),
        .cmd       (cmd),
        .addr      (addr),
        .go        (go),
        .done      (done),
        .fail_set  (fail_set),
        .op        (op)
    );

    isp_mem_model #(
        .DW(DW), .AW(AW), .WORDS(WORDS), .PAGE_WORDS(PAGE_WORDS)
    ) u_mem (
        .clk       (clk),
        .rst       (rst),
        .addr      (addr),
        .prog_en   (done && op == CMD_PROG),
        .prog_data (data),
        .erase_en  (done && op == CMD_ERASE),
        .rdata     (mem_rdata)
    );

    // R7: the failure flag is never left low after a refusal
    a_r7_flag_visible: assert property (@(posedge clk) disable iff (rst)
        fail_set |=> (fail && !cpu_stall));

endmodule

// File: tb/tb_flash_isp_ctrl.sv
module tb_flash_isp_ctrl;
    localparam int NW    = 52;
    localparam int SHORT = 2;
    localparam int LONG  = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        prot_open = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_off = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        cpu_stall;

    int total = 0;
    int bad   = 0;
    logic [31:0] model [NW];

    always #5 clk = ~clk;

    flash_isp_ctrl dut (
        .clk(clk), .rst(rst), .prot_open(prot_open), .reg_wr(reg_wr),
        .reg_off(reg_off), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cpu_stall(cpu_stall)
    );

    // entry: {ctrl[3:0], cmd[1:0], addr[7:0], wdata[31:0]}
    localparam logic [45:0] VEC [16] = '{
        {4'hF, 2'd0, 8'd5,  32'h0},          // R1 R3 erased read
        {4'hF, 2'd1, 8'd5,  32'hF0F0FF00},   // R4
        {4'hF, 2'd1, 8'd5,  32'h0FF0F0FF},   // R4 merge
        {4'hF, 2'd0, 8'd5,  32'h0},          // R3
        {4'hF, 2'd1, 8'd6,  32'h12345678},
        {4'hF, 2'd2, 8'd4,  32'hAAAA5555},   // R5 page 4..7
        {4'hF, 2'd0, 8'd6,  32'h0},          // R5
        {4'hB, 2'd1, 8'd40, 32'h0},          // R7 no boot permission
        {4'hF, 2'd0, 8'd40, 32'h0},
        {4'hF, 2'd2, 8'd52, 32'h0},          // R7 out of range
        {4'hF, 2'd3, 8'd0,  32'h0},          // R7 bad command
        {4'hE, 2'd0, 8'd0,  32'h0},          // R7 disabled
        {4'h3, 2'd1, 8'd50, 32'h0},          // R7 no cfg permission
        {4'hF, 2'd1, 8'd50, 32'h0000FFFF},
        {4'hF, 2'd0, 8'd50, 32'h0},
        {4'h1, 2'd0, 8'd50, 32'h0}           // read needs only enable
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] off, input logic [31:0] val);
        @(negedge clk);
        reg_off = off; reg_wdata = val; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] off, output logic [31:0] val);
        reg_off = off;
        #1;
        val = reg_rdata;
    endtask

    task automatic wait_idle(output int cyc);
        cyc = 0;
        while (cpu_stall && cyc < 100) begin
            cyc++;
            @(negedge clk);
        end
    endtask

    task automatic run_op(input logic [1:0] k, input logic [7:0] a,
                          input logic [31:0] d, output int cyc);
        wr(3'd1, {30'd0, k});
        wr(3'd2, {24'd0, a});
        wr(3'd3, d);
        wr(3'd4, 32'd1);
        wait_idle(cyc);
    endtask

    function automatic logic refuse(input logic [3:0] c, input logic [1:0] k, input int a);
        if (!c[0] || k == 2'd3 || a >= NW) return 1'b1;
        if (k == 2'd0) return 1'b0;
        if (a < 32) return !c[1];
        if (a < 48) return !c[2];
        return !c[3];
    endfunction

    initial begin
        logic [31:0] v;
        int cyc;
        for (int i = 0; i < NW; i++) model[i] = '1;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state of the registers and the stall line
        for (int o = 0; o < 5; o++) begin
            rd(3'(o), v);
            check("R1 reset register", v, 32'd0);
        end
        check("R1 stall low", {31'd0, cpu_stall}, 32'd0);

        // vector table
        for (int i = 0; i < 16; i++) begin
            logic [3:0]  c;
            logic [1:0]  k;
            logic [7:0]  a;
            logic [31:0] d;
            logic        rj;
            logic [31:0] exp_data;
            int          exp_cyc;
            {c, k, a, d} = VEC[i];
            prot_open = 1'b1;
            wr(3'd0, {25'd0, 1'b1, 2'b0, c});
            rj = refuse(c, k, int'(a));
            run_op(k, a, d, cyc);
            exp_cyc  = rj ? 0 : ((k == 2'd2) ? LONG : SHORT);
            exp_data = d;
            if (!rj) begin
                if (k == 2'd0) exp_data = model[a];
                else if (k == 2'd1) model[a] = model[a] & d;
                else for (int w = 0; w < NW; w++)
                    if ((w / 4) == (int'(a) / 4)) model[w] = '1;
            end
            check("R6 R7 busy cycles", 32'(cyc), 32'(exp_cyc));
            rd(3'd0, v);
            check("R7 fail flag", {31'd0, v[6]}, {31'd0, rj});
            rd(3'd3, v);
            check("R3 R4 R5 data register", v, exp_data);
        end

        // R2 locked control bits
        prot_open = 1'b0;
        wr(3'd0, 32'h0);
        rd(3'd0, v);
        check("R2 locked write ignored", {28'd0, v[3:0]}, 32'h1);
        prot_open = 1'b1;
        wr(3'd0, 32'h0F);
        rd(3'd0, v);
        check("R2 unlocked write", {28'd0, v[3:0]}, 32'hF);

        // R8 sticky flag
        run_op(2'd3, 8'd0, 32'h0, cyc);
        run_op(2'd0, 8'd5, 32'h0, cyc);
        check("R8 op runs with flag set", 32'(cyc), 32'(SHORT));
        rd(3'd0, v);
        check("R8 flag survives success", {31'd0, v[6]}, 32'd1);
        prot_open = 1'b0;
        wr(3'd0, 32'h0);
        rd(3'd0, v);
        check("R8 write zero keeps flag", {31'd0, v[6]}, 32'd1);
        wr(3'd0, 32'h40);
        rd(3'd0, v);
        check("R8 write one clears flag", {31'd0, v[6]}, 32'd0);
        check("R8 clear keeps control", {28'd0, v[3:0]}, 32'hF);
        prot_open = 1'b1;

        // R9 writes during busy, R6 start bit visible while busy
        wr(3'd1, 32'd2);
        wr(3'd2, 32'd8);
        wr(3'd4, 32'd1);
        wr(3'd2, 32'd3);
        rd(3'd4, v);
        check("R6 start bit reads 1 while busy", v, 32'd1);
        wait_idle(cyc);
        rd(3'd2, v);
        check("R9 address write ignored", v, 32'd8);
        rd(3'd4, v);
        check("R6 start bit self-cleared", v, 32'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule